// File: doc/BRIEF.md
# Twin-Plane DMA Channel

This block is one memory-to-memory DMA channel driven through a small word-addressed register window. It keeps two descriptor planes. Each plane holds a source address, a destination address and a count of transfer units. Software can therefore prepare the next transfer while the current one is moving data. A command register starts the channel, arms the alternate plane, or ends the queue. A separate halt register stops the channel at once. Status bits tell software whether a transfer is active and whether the two-plane queue is active.

Data moves one unit at a time over a request/acknowledge memory port. Each unit is a read of the source followed by a write of the same data to the destination. The unit is 1, 2 or 4 bytes, as configured. After every unit the channel steps both addresses by the unit size and lowers the count. Software can read the count at any time to work out partial progress. When a plane's count reaches zero, the channel sets a sticky completion flag that software clears by writing a one.

Top module: `twin_plane_dma`

## Requirements
- R1: After reset, every readable register (plane fields at word offsets 0x00 to 0x14, config 0x18, status 0x24, flag 0x28) reads 0, `mem_req` is 0 and `irq_done` is 0.
- R2: In single mode (config bits [3:2] = 00), a write of 1 to bit 0 of the command register (0x1C) copies the plane 0 count of units from plane 0 source to plane 0 destination. Each unit is a read (`mem_we`=0), then a write (`mem_we`=1) of the data read.
- R3: Config bits [1:0] select the unit: 0 gives 1 byte, 1 gives 2 bytes, 2 gives 4 bytes. `mem_size` carries that code during every access, and both addresses advance by the unit after each unit.
- R4: The count decreases by one per completed unit. After a plane completes, its count reads 0, and its source and destination read their start values plus count times unit bytes.
- R5: The completion flag (bit 0 at 0x28, also `irq_done`) rises when a plane's count reaches zero. A write of 0 leaves it set. A write with bit 0 = 1 clears it. A new completion in the same cycle as a clear wins.
- R6: In double-set mode (config bits [3:2] = 11), a start without the next bit (command bit 1) runs plane 0. A start with the next bit from idle runs the plane after the one last started, so successive such starts alternate.
- R7: In double-set mode, a start with the next bit while busy arms the alternate plane. When the current plane completes, the channel runs the alternate plane without going idle.
- R8: Writing command bit 2 (queue end) drops any armed plane and returns the selection to plane 0. The running plane still finishes, then the channel goes idle.
- R9: Writing 1 to bit 0 of the halt register (0x20) stops the channel in that cycle. `mem_req` is 0 from the next cycle, the status reads 0, no completion is flagged, and the selection returns to plane 0.
- R10: Status bit 0 (0x24) is 1 while a transfer is active. Status bit 2 is 1 while active in double-set mode. Both are 0 when idle.
- R11: While busy, writes to the source, destination or count of the active plane are ignored. Writes to the other plane take effect.
- R12: With a mixed mode setting (config bits [3:2] = 01 or 10), start commands are ignored: no memory request and the status stays 0.
- R13: A plane started with count 0 completes without any memory access and sets the completion flag.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_addr | input | REG_AW | Register byte address (word aligned) |
| reg_wr | input | 1 | Register write strobe |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` (combinational) |
| mem_req | output | 1 | Memory access request, held until acknowledged |
| mem_we | output | 1 | 1 for a write access, 0 for a read access |
| mem_addr | output | ADDR_W | Byte address of the access |
| mem_size | output | 2 | Unit size code of the access |
| mem_wdata | output | DATA_W | Write data, unit in the low bytes |
| mem_ack | input | 1 | One-cycle acknowledge; read data valid with it |
| mem_rdata | input | DATA_W | Read data, unit in the low bytes |
| irq_done | output | 1 | Sticky completion flag |

## Verification
In double-set mode, an arm command (start plus next bit) can land in the same cycle as the sequencer's completion decision for the running plane. The decision must then merge the fresh arm with the armed-plane state instead of letting the channel fall idle. The bench provokes this with a memory that never stalls: it sweeps the arm write across the cycles before, at and after the completion of a one-unit plane 0. In every case, plane 1's data must be copied and both counts must read zero once the channel is idle. The completion flag must also be set, since an arm that arrives after idle starts plane 1 by alternation.

// File: rtl/tpd_pkg.sv
package tpd_pkg;

   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_READ  = 2'd1,
      ST_WRITE = 2'd2
   } seq_state_t;

   localparam logic [1:0] FLD_SRC = 2'd0;
   localparam logic [1:0] FLD_DST = 2'd1;
   localparam logic [1:0] FLD_CNT = 2'd2;

   // word indices of the register window
   localparam int IDX_CFG  = 6;
   localparam int IDX_CMD  = 7;
   localparam int IDX_HALT = 8;
   localparam int IDX_STAT = 9;
   localparam int IDX_FLAG = 10;

   localparam int FIELDS_PER_PLANE = 3;

   function automatic logic [2:0] unit_bytes(input logic [1:0] code);
      case (code)
         2'd1:    return 3'd2;
         2'd2:    return 3'd4;
         default: return 3'd1;
      endcase
   endfunction

endpackage

// File: rtl/tpd_plane_bank.sv
module tpd_plane_bank import tpd_pkg::*; #(
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned CNT_W  = 25,
   parameter int unsigned NPLANE = 2
)(
   input  logic                           clk,
   input  logic                           rst_n,
   input  logic                           wr_en,
   input  logic                           wr_plane,
   input  logic [1:0]                     wr_field,
   input  logic [31:0]                    wr_data,
   input  logic                           busy,
   input  logic                           act_plane,
   input  logic                           step,
   input  logic [2:0]                     step_bytes,
   output logic [NPLANE-1:0][ADDR_W-1:0]  src_o,
   output logic [NPLANE-1:0][ADDR_W-1:0]  dst_o,
   output logic [NPLANE-1:0][CNT_W-1:0]   cnt_o
);

   for (genvar p = 0; p < NPLANE; p++) begin : g_plane
      logic [ADDR_W-1:0] src_r, dst_r;
      logic [CNT_W-1:0]  cnt_r;
      logic              locked, sel_wr, sel_step;

      assign locked   = busy && (act_plane == 1'(p));
      assign sel_wr   = wr_en && (wr_plane == 1'(p)) && !locked;
      assign sel_step = step && (act_plane == 1'(p));

      always_ff @(posedge clk) begin
         if (!rst_n) begin
            src_r <= '0;
            dst_r <= '0;
            cnt_r <= '0;
         end else if (sel_step) begin
            src_r <= src_r + ADDR_W'(step_bytes);
            dst_r <= dst_r + ADDR_W'(step_bytes);
            cnt_r <= cnt_r - CNT_W'(1);
         end else if (sel_wr) begin
            case (wr_field)
               FLD_SRC: src_r <= wr_data[ADDR_W-1:0];
               FLD_DST: dst_r <= wr_data[ADDR_W-1:0];
               FLD_CNT: cnt_r <= wr_data[CNT_W-1:0];
               default: ;
            endcase
         end
      end

      assign src_o[p] = src_r;
      assign dst_o[p] = dst_r;
      assign cnt_o[p] = cnt_r;
   end

endmodule

// File: rtl/tpd_sequencer.sv
module tpd_sequencer import tpd_pkg::*; #(
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned DATA_W = 32,
   parameter int unsigned CNT_W  = 25
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic              cmd_wr,
   input  logic [2:0]        cmd_bits,
   input  logic              halt_wr,
   input  logic              irq_clr,
   input  logic              dbl_mode,
   input  logic              mode_bad,
   input  logic [CNT_W-1:0]  cnt_act,
   input  logic [ADDR_W-1:0] src_act,
   input  logic [ADDR_W-1:0] dst_act,
   input  logic              mem_ack,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic              mem_req,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [DATA_W-1:0] mem_wdata,
   output logic              step,
   output logic              act_plane,
   output logic              running,
   output logic              queue_busy,
   output logic              irq_done
);

   seq_state_t        state_q;
   logic              pend_q, sel_q, act_q, irq_q;
   logic [DATA_W-1:0] hold_q;

   logic qend_now, go_now, arm_now, cnt_zero, start_plane, chain_now;

   always_comb begin
      qend_now    = cmd_wr && cmd_bits[2] && !halt_wr;
      go_now      = cmd_wr && cmd_bits[0] && !cmd_bits[2] && !mode_bad && !halt_wr;
      arm_now     = go_now && cmd_bits[1] && dbl_mode && (state_q != ST_IDLE);
      start_plane = (dbl_mode && cmd_bits[1]) ? sel_q : 1'b0;
      cnt_zero    = (cnt_act == '0);
      chain_now   = dbl_mode && ((pend_q && !qend_now) || arm_now);
      mem_req     = ((state_q == ST_READ) && !cnt_zero) || (state_q == ST_WRITE);
      mem_we      = (state_q == ST_WRITE);
      mem_addr    = (state_q == ST_WRITE) ? dst_act : src_act;
      step        = (state_q == ST_WRITE) && mem_ack && !halt_wr;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         pend_q  <= 1'b0;
         sel_q   <= 1'b0;
         act_q   <= 1'b0;
         irq_q   <= 1'b0;
         hold_q  <= '0;
      end else begin
         if (irq_clr) irq_q <= 1'b0;
         if (halt_wr) begin
            state_q <= ST_IDLE;
            pend_q  <= 1'b0;
            sel_q   <= 1'b0;
         end else begin
            if (qend_now) begin
               pend_q <= 1'b0;
               sel_q  <= 1'b0;
            end else if (go_now && state_q == ST_IDLE) begin
               act_q   <= start_plane;
               sel_q   <= dbl_mode ? ~start_plane : 1'b0;
               state_q <= ST_READ;
            end else if (arm_now && !pend_q) begin
               pend_q <= 1'b1;
               sel_q  <= act_q;
            end
            case (state_q)
               ST_READ: begin
                  if (cnt_zero) begin
                     irq_q <= 1'b1;
                     if (chain_now) begin
                        act_q  <= ~act_q;
                        pend_q <= 1'b0;
                        sel_q  <= act_q;
                     end else begin
                        state_q <= ST_IDLE;
                        pend_q  <= 1'b0;
                     end
                  end else if (mem_ack) begin
                     hold_q  <= mem_rdata;
                     state_q <= ST_WRITE;
                  end
               end
               ST_WRITE: if (mem_ack) state_q <= ST_READ;
               default: ;
            endcase
         end
      end
   end

   assign mem_wdata  = hold_q;
   assign act_plane  = act_q;
   assign running    = (state_q != ST_IDLE);
   assign queue_busy = running && dbl_mode;
   assign irq_done   = irq_q;

endmodule

// File: rtl/twin_plane_dma.sv
module twin_plane_dma import tpd_pkg::*; #(
   parameter int unsigned ADDR_W = 32,
   parameter int unsigned DATA_W = 32,
   parameter int unsigned CNT_W  = 25,
   parameter int unsigned REG_AW = 6
)(
   input  logic              clk,
   input  logic              rst_n,
   input  logic [REG_AW-1:0] reg_addr,
   input  logic              reg_wr,
   input  logic [31:0]       reg_wdata,
   output logic [31:0]       reg_rdata,
   output logic              mem_req,
   output logic              mem_we,
   output logic [ADDR_W-1:0] mem_addr,
   output logic [1:0]        mem_size,
   output logic [DATA_W-1:0] mem_wdata,
   input  logic              mem_ack,
   input  logic [DATA_W-1:0] mem_rdata,
   output logic              irq_done
);

   localparam int unsigned IDX_W  = REG_AW - 2;
   localparam int unsigned NPLANE = 2;

   if (CNT_W < 25 || CNT_W > 32) begin : g_bad_cnt
      $error("CNT_W must hold a 16 MiB byte-unit count and fit a register");
   end
   if (ADDR_W < 8 || ADDR_W > 32) begin : g_bad_addr
      $error("ADDR_W must lie between 8 and 32");
   end
   if (DATA_W != 32) begin : g_bad_data
      $error("DATA_W must be 32 to carry a 4-byte unit");
   end
   if (REG_AW < 6) begin : g_bad_reg
      $error("REG_AW too small for the register window");
   end

   logic [IDX_W-1:0] idx;
   logic [3:0]       cfg_q;
   logic             plane_wr, plane_sel;
   logic [1:0]       field_sel;
   logic             cmd_wr, halt_wr, irq_clr, dbl_mode, mode_bad;
   logic             step, act_plane, running, queue_busy;

   logic [NPLANE-1:0][ADDR_W-1:0] src_q, dst_q;
   logic [NPLANE-1:0][CNT_W-1:0]  cnt_q;

   assign idx = reg_addr[REG_AW-1:2];

   always_comb begin
      plane_wr  = 1'b0;
      plane_sel = 1'b0;
      field_sel = FLD_SRC;
      if (int'(idx) < NPLANE * FIELDS_PER_PLANE) begin
         plane_wr  = reg_wr;
         plane_sel = (int'(idx) >= FIELDS_PER_PLANE);
         field_sel = 2'(int'(idx) - (plane_sel ? FIELDS_PER_PLANE : 0));
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)                             cfg_q <= '0;
      else if (reg_wr && int'(idx) == IDX_CFG) cfg_q <= reg_wdata[3:0];
   end

   assign dbl_mode = (cfg_q[3:2] == 2'b11);
   assign mode_bad = ^cfg_q[3:2];
   assign cmd_wr   = reg_wr && int'(idx) == IDX_CMD;
   assign halt_wr  = reg_wr && int'(idx) == IDX_HALT && reg_wdata[0];
   assign irq_clr  = reg_wr && int'(idx) == IDX_FLAG && reg_wdata[0];
   assign mem_size = cfg_q[1:0];

   tpd_plane_bank #(.ADDR_W(ADDR_W), .CNT_W(CNT_W), .NPLANE(NPLANE)) u_bank (
      .clk        (clk),
      .rst_n      (rst_n),
      .wr_en      (plane_wr),
      .wr_plane   (plane_sel),
      .wr_field   (field_sel),
      .wr_data    (reg_wdata),
      .busy       (running),
      .act_plane  (act_plane),
      .step       (step),
      .step_bytes (unit_bytes(cfg_q[1:0])),
      .src_o      (src_q),
      .dst_o      (dst_q),
      .cnt_o      (cnt_q)
   );

   tpd_sequencer #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W)) u_seq (
      .clk        (clk),
      .rst_n      (rst_n),
      .cmd_wr     (cmd_wr),
      .cmd_bits   (reg_wdata[2:0]),
      .halt_wr    (halt_wr),
      .irq_clr    (irq_clr),
      .dbl_mode   (dbl_mode),
      .mode_bad   (mode_bad),
      .cnt_act    (cnt_q[act_plane]),
      .src_act    (src_q[act_plane]),
      .dst_act    (dst_q[act_plane]),
      .mem_ack    (mem_ack),
      .mem_rdata  (mem_rdata),
      .mem_req    (mem_req),
      .mem_we     (mem_we),
      .mem_addr   (mem_addr),
      .mem_wdata  (mem_wdata),
      .step       (step),
      .act_plane  (act_plane),
      .running    (running),
      .queue_busy (queue_busy),
      .irq_done   (irq_done)
   );

   always_comb begin
      reg_rdata = '0;
      case (int'(idx))
         0:        reg_rdata = 32'(src_q[0]);
         1:        reg_rdata = 32'(dst_q[0]);
         2:        reg_rdata = 32'(cnt_q[0]);
         3:        reg_rdata = 32'(src_q[1]);
         4:        reg_rdata = 32'(dst_q[1]);
         5:        reg_rdata = 32'(cnt_q[1]);
         IDX_CFG:  reg_rdata = {28'd0, cfg_q};
         IDX_STAT: reg_rdata = {29'd0, queue_busy, 1'b0, running};
         IDX_FLAG: reg_rdata = {31'd0, irq_done};
         default:  reg_rdata = '0;
      endcase
   end

endmodule

// File: rtl/tpd_checker.sv
module tpd_checker #(
   parameter int unsigned ADDR_W = 32
)(
   input logic              clk,
   input logic              rst_n,
   input logic              halt_wr,
   input logic              irq_clr,
   input logic              mode_bad,
   input logic              running,
   input logic              queue_busy,
   input logic              mem_req,
   input logic              mem_ack,
   input logic              mem_we,
   input logic [ADDR_W-1:0] mem_addr,
   input logic              irq_done
);

   assert_addr_hold_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (mem_req && !mem_ack) |=> (!mem_req || ($stable(mem_addr) && $stable(mem_we))));

   assert_flag_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
      (irq_done && !irq_clr) |=> irq_done);

   assert_flag_rise_R5: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq_done) |-> $past(running));

   assert_halt_stop_R9: assert property (@(posedge clk) disable iff (!rst_n)
      halt_wr |=> (!running && !mem_req));

   assert_queue_in_run_R10: assert property (@(posedge clk) disable iff (!rst_n)
      queue_busy |-> running);

   assert_idle_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
      !running |-> !mem_req);

   assert_mixed_blocked_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (mode_bad && !running) |=> !running);

endmodule

bind twin_plane_dma tpd_checker #(.ADDR_W(ADDR_W)) u_chk (
   .clk        (clk),
   .rst_n      (rst_n),
   .halt_wr    (halt_wr),
   .irq_clr    (irq_clr),
   .mode_bad   (mode_bad),
   .running    (running),
   .queue_busy (queue_busy),
   .mem_req    (mem_req),
   .mem_ack    (mem_ack),
   .mem_we     (mem_we),
   .mem_addr   (mem_addr),
   .irq_done   (irq_done)
);

// File: tb/twin_plane_dma_bench.sv
`timescale 1ns/1ps
module twin_plane_dma_bench;

   localparam logic [5:0] A_SRC0 = 6'h00, A_DST0 = 6'h04, A_CNT0 = 6'h08;
   localparam logic [5:0] A_SRC1 = 6'h0C, A_DST1 = 6'h10, A_CNT1 = 6'h14;
   localparam logic [5:0] A_CFG = 6'h18, A_CMD = 6'h1C, A_HALT = 6'h20;
   localparam logic [5:0] A_STAT = 6'h24, A_FLAG = 6'h28;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [5:0]  reg_addr = '0;
   logic        reg_wr = 1'b0;
   logic [31:0] reg_wdata = '0;
   logic [31:0] reg_rdata;
   logic        mem_req, mem_we;
   logic [31:0] mem_addr, mem_wdata;
   logic [1:0]  mem_size;
   logic        mem_ack = 1'b0;
   logic [31:0] mem_rdata = '0;
   logic        irq_done;

   always #2 clk = ~clk;

   twin_plane_dma u_twin_plane_dma (
      .clk(clk), .rst_n(rst_n), .reg_addr(reg_addr), .reg_wr(reg_wr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .mem_req(mem_req),
      .mem_we(mem_we), .mem_addr(mem_addr), .mem_size(mem_size),
      .mem_wdata(mem_wdata), .mem_ack(mem_ack), .mem_rdata(mem_rdata),
      .irq_done(irq_done)
   );

   int checks = 0, fails = 0, cyc = 0, req_cycles = 0, order_err = 0, size_err = 0;
   logic       stall_en = 1'b1, fill_en = 1'b0;
   logic [7:0] fill_seed = '0;
   logic [1:0] cur_code = '0;
   logic [7:0] mem [0:255];
   logic [31:0] last_rd = '0;
   logic        rd_seen = 1'b0;
   bit          done = 0;

   function automatic logic [7:0] fbyte(input logic [7:0] i, input logic [7:0] s);
      return 8'(i * 8'd37) ^ s ^ {i[2:0], i[7:3]};
   endfunction

   function automatic int ubytes(input logic [1:0] c);
      return (c == 2'd1) ? 2 : (c == 2'd2) ? 4 : 1;
   endfunction

   function automatic logic [31:0] umask(input logic [1:0] c);
      return (c == 2'd1) ? 32'h0000_FFFF : (c == 2'd2) ? 32'hFFFF_FFFF : 32'h0000_00FF;
   endfunction

   // memory responder
   always @(posedge clk) begin
      if (fill_en) begin
         for (int i = 0; i < 256; i++) mem[i] <= fbyte(8'(i), fill_seed);
      end else if (mem_req && mem_ack && mem_we) begin
         for (int b = 0; b < 4; b++)
            if (b < ubytes(mem_size)) mem[8'(mem_addr[7:0] + 8'(b))] <= mem_wdata[8*b +: 8];
      end
      mem_rdata <= {mem[8'(mem_addr[7:0] + 8'd3)], mem[8'(mem_addr[7:0] + 8'd2)],
                    mem[8'(mem_addr[7:0] + 8'd1)], mem[mem_addr[7:0]]};
      if (!rst_n) mem_ack <= 1'b0;
      else        mem_ack <= mem_req && !mem_ack && (!stall_en || ($urandom % 3 != 0));
   end

   // port monitor: read-then-write order, data carried, size code
   always @(negedge clk) begin
      if (rst_n && mem_req) begin
         req_cycles++;
         if (mem_size != cur_code) size_err++;
         if (mem_ack && !mem_we) begin
            last_rd = mem_rdata;
            rd_seen = 1'b1;
         end else if (mem_ack && mem_we) begin
            if (!rd_seen || ((mem_wdata ^ last_rd) & umask(mem_size)) != 0) order_err++;
            rd_seen = 1'b0;
         end
      end
   end

   always @(posedge clk) begin
      cyc++;
      if (cyc > 150000 && !done) begin
         fails++;
         $display("FAIL watchdog: actual %0d cycles expected completion earlier", cyc);
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s: actual %0h expected %0h", req, act, exp);
      end
   endtask

   task automatic wr(input logic [5:0] a, input logic [31:0] d);
      @(negedge clk);
      reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
      if (a == A_CFG) cur_code = d[1:0];
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd(input logic [5:0] a, output logic [31:0] d);
      @(negedge clk);
      reg_addr = a;
      #1 d = reg_rdata;
   endtask

   task automatic fill(input logic [7:0] s);
      @(negedge clk);
      fill_seed = s; fill_en = 1'b1;
      @(negedge clk);
      fill_en = 1'b0;
   endtask

   task automatic wait_idle();
      @(negedge clk);
      reg_addr = A_STAT;
      for (int k = 0; k < 4000; k++) begin
         @(negedge clk);
         #1 if (reg_rdata[0] == 1'b0) break;
      end
   endtask

   task automatic wait_cycles(input int n);
      for (int k = 0; k < n; k++) @(negedge clk);
   endtask

   task automatic check_copy(input int src, input int dst, input int len,
                             input logic [7:0] s, input string req);
      int bad = 0;
      for (int k = 0; k < len; k++)
         if (mem[8'(dst + k)] !== fbyte(8'(src + k), s)) bad++;
      chk(bad == 0, req, bad, 0);
   endtask

   task automatic load_plane(input int p, input logic [31:0] s, input logic [31:0] d,
                             input logic [31:0] c);
      wr(p == 0 ? A_SRC0 : A_SRC1, s);
      wr(p == 0 ? A_DST0 : A_DST1, d);
      wr(p == 0 ? A_CNT0 : A_CNT1, c);
   endtask

   logic [31:0] v, v2;

   initial begin
      void'($urandom(32'd24681));
      repeat (4) @(negedge clk);
      rst_n = 1'b1;

      // R1 reset state
      for (int i = 0; i <= 10; i++) begin
         rd(6'(i * 4), v);
         chk(v == 0, "R1 register reset", v, 0);
      end
      chk(mem_req == 0 && irq_done == 0, "R1 port reset", {mem_req, irq_done}, 0);

      // R2 R3 R4 random single-mode transfers
      for (int t = 0; t < 8; t++) begin
         int code = $urandom % 3;
         int cnt  = 1 + $urandom % 8;
         int src  = $urandom % 64;
         int dst  = 128 + $urandom % 64;
         int len  = cnt << code;
         logic [7:0] s = 8'($urandom);
         fill(s);
         load_plane(0, src, dst, cnt);
         wr(A_CFG, 32'(code));
         wr(A_FLAG, 1);
         wr(A_CMD, 1);
         wait_idle();
         check_copy(src, dst, len, s, "R2 single copy");
         rd(A_CNT0, v);  chk(v == 0, "R4 count drained", v, 0);
         rd(A_SRC0, v);  chk(v == 32'(src + len), "R3 source stepped", v, 32'(src + len));
         rd(A_DST0, v);  chk(v == 32'(dst + len), "R4 destination stepped", v, 32'(dst + len));
         chk(irq_done == 1, "R5 flag after completion", irq_done, 1);
      end
      chk(order_err == 0, "R2 read-then-write order", order_err, 0);
      chk(size_err == 0, "R3 size code on port", size_err, 0);

      // R13 zero count, then R5 sticky flag
      wr(A_FLAG, 1);
      wr(A_CFG, 0);
      wr(A_CNT0, 0);
      v2 = 32'(req_cycles);
      wr(A_CMD, 1);
      wait_cycles(3);
      chk(irq_done == 1, "R13 zero count flags", irq_done, 1);
      chk(32'(req_cycles) == v2, "R13 no memory access", req_cycles, v2);
      wr(A_FLAG, 0);
      wait_cycles(4);
      rd(A_FLAG, v);
      chk(v == 1, "R5 write 0 keeps flag", v, 1);
      wr(A_FLAG, 1);
      rd(A_FLAG, v);
      chk(v == 0, "R5 write 1 clears flag", v, 0);

      // R12 mixed mode ignored
      for (int m = 1; m <= 2; m++) begin
         wr(A_CNT0, 5);
         wr(A_CFG, 32'(m << 2));
         v2 = 32'(req_cycles);
         wr(A_CMD, 1);
         wait_cycles(4);
         rd(A_STAT, v);
         chk(v == 0 && 32'(req_cycles) == v2, "R12 mixed mode start ignored", v, 0);
         rd(A_CNT0, v);
         chk(v == 5, "R12 count untouched", v, 5);
      end

      // R9 R10 R11 halt and write guard in single mode
      wr(A_CFG, 0);
      wr(A_FLAG, 1);
      load_plane(0, 0, 128, 30);
      wr(A_CMD, 1);
      rd(A_STAT, v);
      chk(v == 1, "R10 single busy status", v, 1);
      wr(A_CNT0, 99);
      wr(A_SRC0, 32'h55);
      wr(A_CNT1, 7);
      rd(A_CNT0, v);
      chk(v != 99 && v <= 30, "R11 active count write ignored", v, 30);
      rd(A_SRC0, v);
      chk(v != 32'h55, "R11 active source write ignored", v, 0);
      rd(A_CNT1, v);
      chk(v == 7, "R11 inactive plane writable", v, 7);
      wr(A_HALT, 1);
      chk(mem_req == 0, "R9 request dropped after halt", mem_req, 0);
      rd(A_STAT, v);
      chk(v == 0, "R9 status idle after halt", v, 0);
      rd(A_CNT0, v);
      chk(v > 0 && v < 30, "R9 partial count kept", v, 15);
      chk(irq_done == 0, "R9 no flag on halt", irq_done, 0);

      // R7 R10 chained planes in double mode
      fill(8'h3C);
      wr(A_CFG, 32'hE);
      load_plane(0, 0, 128, 4);
      load_plane(1, 32, 192, 3);
      wr(A_CMD, 1);
      rd(A_STAT, v);
      chk(v == 5, "R10 double busy status", v, 5);
      wr(A_CMD, 3);
      wait_idle();
      rd(A_CNT1, v);
      chk(v == 0, "R7 chained without idle", v, 0);
      check_copy(0, 128, 16, 8'h3C, "R7 plane 0 copy");
      check_copy(32, 192, 12, 8'h3C, "R7 plane 1 copy");

      // R6 alternation of starts
      begin
         int order [4] = '{0, 1, 0, 0};
         logic [31:0] cmds [4] = '{3, 3, 3, 1};
         for (int k = 0; k < 4; k++) begin
            wr(A_CNT0, 1);
            wr(A_CNT1, 2);
            wr(A_CMD, cmds[k]);
            wait_idle();
            rd(order[k] == 0 ? A_CNT1 : A_CNT0, v);
            chk(v == (order[k] == 0 ? 2 : 1), "R6 start plane selection", v, order[k]);
         end
      end

      // R8 queue end
      wr(A_CFG, 32'hC);
      load_plane(0, 0, 128, 6);
      wr(A_CNT1, 2);
      wr(A_CMD, 1);
      wr(A_CMD, 3);
      wr(A_CMD, 4);
      wait_idle();
      rd(A_CNT0, v);  chk(v == 0, "R8 running plane finishes", v, 0);
      rd(A_CNT1, v);  chk(v == 2, "R8 armed plane dropped", v, 2);
      wr(A_CNT0, 1);
      wr(A_CMD, 3);
      wait_idle();
      rd(A_CNT0, v);  v2 = v;
      rd(A_CNT1, v);
      chk(v2 == 0 && v == 2, "R8 selection back to plane 0", {v2[15:0], v[15:0]}, 2);

      // R9 halt resets selection in double mode
      wr(A_CNT0, 20);
      wr(A_CNT1, 3);
      wr(A_CMD, 1);
      wait_cycles(5);
      wr(A_HALT, 1);
      wr(A_CNT0, 2);
      wr(A_CMD, 3);
      wait_idle();
      rd(A_CNT0, v);  v2 = v;
      rd(A_CNT1, v);
      chk(v2 == 0 && v == 3, "R9 halt resets selection", {v2[15:0], v[15:0]}, 3);

      // arm command landing across the completion decision
      stall_en = 1'b0;
      for (int off = 0; off < 7; off++) begin
         fill(8'(off + 8'h71));
         wr(A_CFG, 32'hD);
         wr(A_FLAG, 1);
         load_plane(0, 4, 140, 1);
         load_plane(1, 40, 200, 2);
         wr(A_CMD, 1);
         wait_cycles(off);
         wr(A_CMD, 3);
         wait_idle();
         rd(A_CNT1, v);
         chk(v == 0, "R7 arm at completion chains", v, 0);
         check_copy(40, 200, 4, 8'(off + 8'h71), "R7 arm at completion copy");
         chk(irq_done == 1, "R5 flag after chained run", irq_done, 1);
      end

      done = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

endmodule